// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block provides the timing skeleton for a small processor core with a two-stage fetch/execute pipeline. It splits the system clock into four non-overlapping phase strobes, and each full rotation of the strobes is one instruction cycle. Within each cycle it gives one execute slot, for the word fetched in the previous cycle, and one fetch slot, for the next word. When the executing instruction tells the sequencer that it changed the program counter, the sequencer turns the following instruction cycle into a bubble.

After an accepted reset, and after every wake-up from halt, the sequencer holds the core idle for a fixed start-up period. Only then does it let the phases run, starting at phase 1. A halt request takes effect at the end of the instruction cycle in progress. A wake event restarts the sequencer through the start-up hold. The reset input is filtered, so short low glitches do nothing.

Top module: `instr_cycle_seq`

## Requirements
- R1: While `running` is high, exactly one bit of `phase` is high. Bit 0 is phase 1 and bit 3 is phase 4. The high bit advances one position per clock, from bit 0 up to bit 3 and then back to bit 0. While `running` is low, `phase` is all zero.
- R2: Each instruction cycle lasts four clocks. `exec_en` is high only during phase 2 and `fetch_en` only during phase 4. Each pulse is one clock wide.
- R3: `rst_n` is accepted as a reset only once it has been sampled low on 4 consecutive rising edges. A low pulse of 3 clocks or less leaves the sequencer running undisturbed.
- R4: After an accepted reset, all outputs are low. Once `rst_n` goes high, the outputs stay low for 1024 clocks. Phase 1 then appears on the next clock.
- R5: If `pc_changed` is high on the clock where `exec_en` is high, the next instruction cycle is a bubble. In that cycle `flush` is high for all four clocks, `exec_en` stays low, and `fetch_en` still pulses in phase 4.
- R6: `pc_changed` has no effect when it is high outside the `exec_en` clock.
- R7: If `halt_req` is high on any clock of a running instruction cycle, the sequencer stops right after phase 4 of that cycle. `running`, `phase`, `fetch_en` and `exec_en` then stay low.
- R8: A `wake` pulse while halted starts a new 1024-clock hold, and the phases then restart at phase 1. `wake` while running, and `halt_req` during a start-up hold, are ignored.
- R9: A bubble that was requested in the last instruction cycle before a halt is kept across the halt. The first instruction cycle after the wake-up hold is then the bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, filtered by length |
| halt_req | input | 1 | Request to halt at the end of the current cycle |
| wake | input | 1 | Wake-up event while halted |
| pc_changed | input | 1 | The executing instruction changed the program counter |
| phase | output | 4 | One-hot phase strobes, bit 0 = phase 1 |
| fetch_en | output | 1 | Latch the fetched word (phase 4) |
| exec_en | output | 1 | Execute the held word (phase 2) |
| flush | output | 1 | The held word is void; bubble cycle in progress |
| running | output | 1 | Phase strobes active |

## Verification
A pipeline flush and a halt can land on the same instruction cycle. This happens when `pc_changed` arrives on the execute clock of the cycle that a `halt_req` is about to end. To provoke it, the bench raises both signals in that one cycle. It then waits out the halt, wakes the core, and checks that the bubble appears in the first cycle after the new start-up hold and not at any earlier point. A reference model advances each clock from the driven inputs alone and is compared with every output on every clock.

// File: rtl/isq_pkg.sv
package isq_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } seq_state_t;

  // Index of the next phase, wrapping at nph.
  function automatic int unsigned phase_next(input int unsigned idx, input int unsigned nph);
    return (idx + 1 >= nph) ? 0 : idx + 1;
  endfunction

  // Strobe vector for a phase index.
  function automatic logic [3:0] phase_strobe(input int unsigned idx);
    logic [3:0] v;
    v = '0;
    v[idx[1:0]] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/isq_rst_filter.sv
module isq_rst_filter #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [MIN_LOW-1:0] hist;

  always_ff @(posedge clk) begin
    hist <= {hist[MIN_LOW-2:0], rst_n};
  end

  // Reset counts only when every recent sample was low
  assign rst_ok = (hist == '0);
endmodule

// File: rtl/isq_startup_timer.sv
module isq_startup_timer #(
  parameter int HOLD_CLKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  output logic expire
);
  localparam int CW = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CLKS - 1);

  logic [CW-1:0] cnt;

  assign expire = count_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !count_en || expire) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/isq_phase_gen.sv
module isq_phase_gen
  import isq_pkg::*;
#(
  parameter int NPH      = 4,
  parameter int EXEC_PH  = 1,
  parameter int FETCH_PH = NPH - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  output logic [NPH-1:0] phase,
  output logic           exec_slot,
  output logic           fetch_slot,
  output logic           cycle_end
);
  localparam int PW = $clog2(NPH);

  logic [PW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst || !run) idx <= '0;
    else             idx <= PW'(phase_next(int'(idx), NPH));
  end

  assign phase      = run ? phase_strobe(int'(idx)) : '0;
  assign exec_slot  = run && (idx == PW'(EXEC_PH));
  assign fetch_slot = run && (idx == PW'(FETCH_PH));
  assign cycle_end  = run && (idx == PW'(NPH - 1));

  // Exactly one strobe while running
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    run |-> $countones(phase) == 1)
    else $error("phase not one-hot");

  // Strobe rotates by one position per clock
  p_rotate_r1: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> phase == {$past(phase[NPH-2:0]), $past(phase[NPH-1])})
    else $error("phase rotation broken");
endmodule

// File: rtl/isq_pipe_ctrl.sv
module isq_pipe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic exec_slot,
  input  logic cycle_end,
  input  logic pc_changed,
  output logic exec_en,
  output logic flush
);
  logic pend;    // pc change seen in current cycle
  logic bubble;  // current cycle is a bubble

  assign exec_en = exec_slot && !bubble;
  assign flush   = run && bubble;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      bubble <= 1'b0;
    end else if (cycle_end) begin
      bubble <= pend;
      pend   <= 1'b0;
    end else if (exec_en && pc_changed) begin
      pend <= 1'b1;
    end
  end

  // A bubble starts only at a cycle boundary
  p_flush_start_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(flush) && $past(run)) |-> $past(cycle_end))
    else $error("flush began mid-cycle");

  // Execute pulse is a single clock
  p_exec_width_r2: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> !exec_en)
    else $error("exec_en wider than one clock");
endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import isq_pkg::*;
#(
  parameter int HOLD_CLKS = 1024,
  parameter int RST_MIN   = 4,
  parameter int NPH       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halt_req,
  input  logic           wake,
  input  logic           pc_changed,
  output logic [NPH-1:0] phase,
  output logic           fetch_en,
  output logic           exec_en,
  output logic           flush,
  output logic           running
);
  seq_state_t state;
  logic rst_ok;
  logic sst_expire;
  logic exec_slot;
  logic fetch_slot;
  logic cycle_end;
  logic halt_pend;
  logic halt_now;

  isq_rst_filter #(.MIN_LOW(RST_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  isq_startup_timer #(.HOLD_CLKS(HOLD_CLKS)) u_sst (
    .clk(clk), .rst(rst_ok), .count_en(state == ST_HOLD), .expire(sst_expire)
  );

  assign running = (state == ST_RUN);

  isq_phase_gen #(.NPH(NPH)) u_ph (
    .clk(clk), .rst(rst_ok), .run(running), .phase(phase),
    .exec_slot(exec_slot), .fetch_slot(fetch_slot), .cycle_end(cycle_end)
  );

  isq_pipe_ctrl u_pipe (
    .clk(clk), .rst(rst_ok), .run(running), .exec_slot(exec_slot),
    .cycle_end(cycle_end), .pc_changed(pc_changed),
    .exec_en(exec_en), .flush(flush)
  );

  assign fetch_en = fetch_slot;
  assign halt_now = cycle_end && (halt_pend || halt_req);

  always_ff @(posedge clk) begin
    if (rst_ok) begin
      state     <= ST_HOLD;
      halt_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_HOLD: if (sst_expire) state <= ST_RUN;
        ST_RUN: begin
          if (halt_now) state <= ST_HALT;
          halt_pend <= cycle_end ? 1'b0 : (halt_pend || halt_req);
        end
        ST_HALT: if (wake) state <= ST_HOLD;
        default: state <= ST_HOLD;
      endcase
    end
  end

  // Running starts only when the start-up timer expires
  p_hold_done_r4: assert property (@(posedge clk) disable iff (rst_ok)
    $rose(running) |-> $past(sst_expire))
    else $error("run began before hold expired");

  // Halt lands right after phase 4
  p_halt_edge_r7: assert property (@(posedge clk) disable iff (rst_ok)
    $fell(running) |-> $past(fetch_en))
    else $error("halt not at cycle end");
endmodule

// File: tb/test_instr_cycle_seq.sv
module test_instr_cycle_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0;
  logic wake = 1'b0;
  logic pc_changed = 1'b0;
  logic [3:0] phase;
  logic fetch_en, exec_en, flush, running;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  instr_cycle_seq i_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake(wake),
    .pc_changed(pc_changed), .phase(phase), .fetch_en(fetch_en),
    .exec_en(exec_en), .flush(flush), .running(running)
  );

  // Reference model: mode 0 hold, 1 run, 2 halted
  int m_mode = 0, m_wait = 0, m_ph = 0, m_low = 0;
  bit m_bub = 0, m_pc = 0, m_halt = 0;

  always @(posedge clk) begin
    bit accepted;
    bit last_ph;
    accepted = (m_low >= 4);
    m_low = rst_n ? 0 : ((m_low < 4) ? m_low + 1 : 4);
    cyc++;
    if (accepted) begin
      m_mode = 0; m_wait = 0; m_ph = 0; m_bub = 0; m_pc = 0; m_halt = 0;
    end else if (m_mode == 0) begin
      if (m_wait == 1023) begin m_mode = 1; m_ph = 0; m_wait = 0; end
      else m_wait++;
    end else if (m_mode == 1) begin
      last_ph = (m_ph == 3);
      if (m_ph == 1 && !m_bub && pc_changed) m_pc = 1;
      if (halt_req) m_halt = 1;
      if (last_ph) begin
        m_bub = m_pc; m_pc = 0; m_ph = 0;
        if (m_halt) m_mode = 2;
        m_halt = 0;
      end else m_ph++;
    end else if (wake) begin
      m_mode = 0; m_wait = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at clk %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      int e_ph;
      e_ph = (m_mode == 1) ? (1 << m_ph) : 0;
      check(phase == 4'(e_ph), "R1 phase", int'(phase), e_ph);
      check(exec_en == (m_mode == 1 && m_ph == 1 && !m_bub), "R2 exec_en", int'(exec_en),
            int'(m_mode == 1 && m_ph == 1 && !m_bub));
      check(fetch_en == (m_mode == 1 && m_ph == 3), "R2 fetch_en", int'(fetch_en),
            int'(m_mode == 1 && m_ph == 3));
      check(flush == (m_mode == 1 && m_bub), "R5 flush", int'(flush), int'(m_mode == 1 && m_bub));
      check(running == (m_mode == 1), "R7 running", int'(running), int'(m_mode == 1));
    end
  end

  task automatic wait_run(output int n);
    n = 0;
    while (!running) begin @(negedge clk); n++; end
  endtask

  task automatic wait_exec();
    do @(negedge clk); while (!exec_en);
  endtask

  initial begin
    int n;
    int cnt;
    // Watchdog
    fork
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (8) @(negedge clk);
    cmp_on = 1'b1;
    check(running == 0 && phase == 0 && flush == 0, "R4 reset state", int'(running), 0);
    rst_n = 1'b1;
    wait_run(n);
    check(n == 1025, "R4 hold length", n, 1025);
    check(phase == 4'b0001, "R4 first phase", int'(phase), 1);

    // R2: four clocks per cycle, one exec and one fetch
    cnt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += int'(exec_en) + int'(fetch_en); end
    check(cnt == 4, "R2 pulses in two cycles", cnt, 4);

    // R5: pc change at execute makes a bubble
    wait_exec();
    pc_changed = 1'b1;
    @(negedge clk); pc_changed = 1'b0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += int'(flush); end
    check(cnt == 4, "R5 flush clocks", cnt, 4);

    // R6: pc change outside execute ignored
    wait_exec();
    @(negedge clk); pc_changed = 1'b1;
    @(negedge clk); pc_changed = 1'b0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); cnt += int'(flush); end
    check(cnt == 0, "R6 no flush", cnt, 0);

    // R3: short reset pulse ignored
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(running == 1, "R3 short pulse ignored", int'(running), 1);

    // R8: wake while running ignored
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    repeat (3) @(negedge clk);
    check(running == 1, "R8 wake ignored", int'(running), 1);

    // R7: halt, then R8 wake
    wait_exec();
    halt_req = 1'b1; @(negedge clk); halt_req = 1'b0;
    repeat (6) @(negedge clk);
    check(running == 0 && phase == 0, "R7 halted", int'(running), 0);
    repeat (20) @(negedge clk);
    check(running == 0, "R7 stays halted", int'(running), 0);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    wait_run(n);
    check(n == 1024, "R8 wake hold length", n, 1024);
    check(phase == 4'b0001 && flush == 0, "R8 restart phase 1", int'(phase), 1);

    // R9: flush and halt in the same cycle
    wait_exec();
    pc_changed = 1'b1; halt_req = 1'b1;
    @(negedge clk); pc_changed = 1'b0; halt_req = 1'b0;
    repeat (4) @(negedge clk);
    check(running == 0 && flush == 0, "R9 halted before bubble", int'(flush), 0);
    // R8: halt during hold ignored
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    halt_req = 1'b1; repeat (10) @(negedge clk); halt_req = 1'b0;
    wait_run(n);
    check(flush == 1 && exec_en == 0, "R9 bubble after wake", int'(flush), 1);
    repeat (8) @(negedge clk);
    check(running == 1, "R8 halt in hold ignored", int'(running), 1);

    // R3: four-clock reset accepted
    rst_n = 1'b0; repeat (5) @(negedge clk);
    check(running == 0 && phase == 0 && fetch_en == 0, "R3 reset accepted", int'(running), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule